// File: doc/BRIEF.md
# Table-Driven SPI Clock Configuration Sequencer

This block brings up the clocking of a board after reset. On a start pulse it captures two sets of board straps: the kind of clock module fitted and a configuration letter. From them it chooses one register-write list for each of three clock devices: an RF reference buffer, a sample-clock buffer and a PLL device. It then writes those lists out over a single SPI master, one register per frame, with a separate chip select for each device.

The lists sit in an internal ROM. Each list entry is an 8-bit register address paired with an 8-bit value. A list stops at its first entry whose address is 0xFF. A list that holds only that marker means the device is left alone in that mode. When no module is fitted, the PLL device still gets a short sequence that resets it and shuts it down, so that it cannot run free. When the last list has ended, the block drops `busy` and raises `done`.

Top module: `clk_cfg_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, all chip selects are high, `sclk` is low, and `busy` and `done` are low.
- R2: The straps are captured only on the clock edge where `start` is accepted, and `start` is accepted only when `busy` is low. A strap change or a `start` pulse during a run does not change the writes of that run.
- R3: Module code 2'b00 is "none", 2'b01 is MMCX-type, 2'b10 is PLL-type, and 2'b11 is treated as "none". Letter code 2'b00 is A, 2'b01 is B, 2'b10 is C, and 2'b11 is treated as A.
- R4: Devices are written in a fixed order: RF reference buffer on `cs_n[0]`, then sample-clock buffer on `cs_n[1]`, then PLL device on `cs_n[2]`. At most one chip select is low at any time.
- R5: Each write is one 24-bit frame sent MSB first in SPI mode 0, with `sclk` idling low and `mosi` changing only on falling edges. Bit 23 is 0 (write), bits 22:21 are 00, bits 20:8 hold the register address zero-extended, and bits 7:0 hold the data. Chip select stays low for all 24 bits.
- R6: An entry with address 0xFF ends its list and produces no frame. A list that holds only this entry produces no frames.
- R7: The RF reference buffer is written only for PLL-type letter A, with the pairs 45←01, 4A←33, 4B←00, 3D←08, 5A←01, in that order.
- R8: The sample-clock buffer always gets 45←x, 51←80, 5A←01. Here x is 01 for "none" and for MMCX-A, and 00 in every other mode.
- R9: With no module, the PLL device gets 00←30, 00←10, 0A←11, 3D←03, 3E←03, 3F←03, 40←01, 41←01. With an MMCX-type module it gets nothing.
- R10: With a PLL-type module, the PLL device gets 00←30, 00←10, 04←02, 05←00, 06←03, 0B←00, 0C←01, 07←00, 08←47, 09←70, 0A←v, 3D/3E/3F←03, 40←w, 41←02, 51←80, 53←80, 45←02, 5A←01. Here v is 40 for C and 08 otherwise, and w is 01 for A and 02 otherwise.
- R11: Between two frames, all chip selects stay high for at least one SCLK period (2·SCLK_HALF clocks).
- R12: `done` rises in the same cycle that `busy` falls, after the PLL list's end marker. It stays high until the next accepted `start`, and it is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a configuration run (single-cycle pulse) |
| strap_mod | input | 2 | Clock-module type strap |
| strap_cfg | input | 2 | Configuration-letter strap |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI serial data out |
| cs_n | output | 3 | Active-low chip selects, one per device |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High once a run has completed |

## Verification
The assertions assume that `rst` is applied at power-up and that the straps and `start` are synchronous to `clk`. They do not assume the straps hold still during a run, because the block keeps its own copy. The stimulus drives the straps and `start` just after a rising edge. It tries every module and letter code, including the two reserved codes. In one run it deliberately changes the straps and pulses `start` while a run is in progress, to confirm that the captured copy is the one that counts.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NDEV    = 3;
  localparam int DEV_W   = 2;
  localparam int IDX_W   = 5;
  localparam int FRAME_W = 24;
  localparam logic [7:0] END_MARK = 8'hFF;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } entry_t;

  function automatic logic [FRAME_W-1:0] make_frame(input entry_t e);
    // write flag, two length bits, 13-bit address, data byte
    return {1'b0, 2'b00, 5'b00000, e.addr, e.data};
  endfunction

  function automatic entry_t pair(input logic [7:0] a, input logic [7:0] d);
    entry_t e;
    e.addr = a;
    e.data = d;
    return e;
  endfunction

  function automatic entry_t tbl_lookup(input logic [DEV_W-1:0] dev,
                                        input logic [1:0] modc,
                                        input logic [1:0] cfgc,
                                        input logic [IDX_W-1:0] idx);
    entry_t e;
    logic [1:0] m;
    logic [1:0] c;
    m = (modc == 2'b11) ? 2'b00 : modc;
    c = (cfgc == 2'b11) ? 2'b00 : cfgc;
    e = pair(END_MARK, END_MARK);
    case (dev)
      2'd0: begin
        if (m == 2'b10 && c == 2'b00) begin
          case (idx)
            5'd0: e = pair(8'h45, 8'h01);
            5'd1: e = pair(8'h4A, 8'h33);
            5'd2: e = pair(8'h4B, 8'h00);
            5'd3: e = pair(8'h3D, 8'h08);
            5'd4: e = pair(8'h5A, 8'h01);
            default: e = pair(END_MARK, END_MARK);
          endcase
        end
      end
      2'd1: begin
        case (idx)
          5'd0: e = pair(8'h45, (m == 2'b00 || (m == 2'b01 && c == 2'b00)) ? 8'h01 : 8'h00);
          5'd1: e = pair(8'h51, 8'h80);
          5'd2: e = pair(8'h5A, 8'h01);
          default: e = pair(END_MARK, END_MARK);
        endcase
      end
      2'd2: begin
        if (m == 2'b00) begin
          case (idx)
            5'd0: e = pair(8'h00, 8'h30);
            5'd1: e = pair(8'h00, 8'h10);
            5'd2: e = pair(8'h0A, 8'h11);
            5'd3: e = pair(8'h3D, 8'h03);
            5'd4: e = pair(8'h3E, 8'h03);
            5'd5: e = pair(8'h3F, 8'h03);
            5'd6: e = pair(8'h40, 8'h01);
            5'd7: e = pair(8'h41, 8'h01);
            default: e = pair(END_MARK, END_MARK);
          endcase
        end else if (m == 2'b10) begin
          case (idx)
            5'd0:  e = pair(8'h00, 8'h30);
            5'd1:  e = pair(8'h00, 8'h10);
            5'd2:  e = pair(8'h04, 8'h02);
            5'd3:  e = pair(8'h05, 8'h00);
            5'd4:  e = pair(8'h06, 8'h03);
            5'd5:  e = pair(8'h0B, 8'h00);
            5'd6:  e = pair(8'h0C, 8'h01);
            5'd7:  e = pair(8'h07, 8'h00);
            5'd8:  e = pair(8'h08, 8'h47);
            5'd9:  e = pair(8'h09, 8'h70);
            5'd10: e = pair(8'h0A, (c == 2'b10) ? 8'h40 : 8'h08);
            5'd11: e = pair(8'h3D, 8'h03);
            5'd12: e = pair(8'h3E, 8'h03);
            5'd13: e = pair(8'h3F, 8'h03);
            5'd14: e = pair(8'h40, (c == 2'b00) ? 8'h01 : 8'h02);
            5'd15: e = pair(8'h41, 8'h02);
            5'd16: e = pair(8'h51, 8'h80);
            5'd17: e = pair(8'h53, 8'h80);
            5'd18: e = pair(8'h45, 8'h02);
            5'd19: e = pair(8'h5A, 8'h01);
            default: e = pair(END_MARK, END_MARK);
          endcase
        end
      end
      default: e = pair(END_MARK, END_MARK);
    endcase
    return e;
  endfunction
endpackage

// File: rtl/clkcfg_rom.sv
module clkcfg_rom
  import clkcfg_pkg::*;
(
  input  logic             clk,
  input  logic [DEV_W-1:0] dev,
  input  logic [1:0]       modc,
  input  logic [1:0]       cfgc,
  input  logic [IDX_W-1:0] idx,
  output entry_t           q
);
  // synchronous read so the table can map onto a block RAM
  always_ff @(posedge clk) begin
    q <= tbl_lookup(dev, modc, cfgc, idx);
  end
endmodule

// File: rtl/clkcfg_spi.sv
module clkcfg_spi
  import clkcfg_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  input  logic [DEV_W-1:0]   dev,
  output logic               sclk,
  output logic               mosi,
  output logic [NDEV-1:0]    cs_n,
  output logic               fin
);
  localparam int CW = $clog2(2*HALF + 1);
  localparam int BW = $clog2(FRAME_W);

  typedef enum logic [1:0] {SP_IDLE, SP_XFER, SP_GAP} sp_t;
  sp_t               st;
  logic [FRAME_W-1:0] sh;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bits;

  assign mosi = sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SP_IDLE;
      sclk <= 1'b0;
      cs_n <= '1;
      sh   <= '0;
      cnt  <= '0;
      bits <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        SP_IDLE: begin
          if (go) begin
            sh   <= frame;
            cs_n <= ~(NDEV'(1) << dev);
            sclk <= 1'b0;
            cnt  <= '0;
            bits <= '0;
            st   <= SP_XFER;
          end
        end
        SP_XFER: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bits == BW'(FRAME_W - 1)) begin
                cs_n <= '1;
                st   <= SP_GAP;
              end else begin
                bits <= bits + 1'b1;
                sh   <= {sh[FRAME_W-2:0], 1'b0};
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SP_GAP: begin
          if (cnt == CW'(2*HALF - 1)) begin
            cnt <= '0;
            fin <= 1'b1;
            st  <= SP_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SP_IDLE;
      endcase
    end
  end

  p_one_cs_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |-> !sclk);
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
  p_gap_cs_high_r11: assert property (@(posedge clk) disable iff (rst)
    (st == SP_GAP) |-> (&cs_n));
endmodule

// File: rtl/clk_cfg_seq.sv
module clk_cfg_seq
  import clkcfg_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] strap_mod,
  input  logic [1:0] strap_cfg,
  output logic       sclk,
  output logic       mosi,
  output logic [2:0] cs_n,
  output logic       busy,
  output logic       done
);
  typedef enum logic [1:0] {T_IDLE, T_FETCH, T_EVAL, T_WAIT} tst_t;
  tst_t             st;
  logic [1:0]       mod_q, cfg_q;
  logic [DEV_W-1:0] dev_q;
  logic [IDX_W-1:0] idx_q;
  logic             go;
  logic             spi_fin;
  entry_t           rom_q;

  clkcfg_rom u_rom (
    .clk  (clk),
    .dev  (dev_q),
    .modc (mod_q),
    .cfgc (cfg_q),
    .idx  (idx_q),
    .q    (rom_q)
  );

  clkcfg_spi #(.HALF(SCLK_HALF)) u_spi (
    .clk   (clk),
    .rst   (rst),
    .go    (go),
    .frame (make_frame(rom_q)),
    .dev   (dev_q),
    .sclk  (sclk),
    .mosi  (mosi),
    .cs_n  (cs_n),
    .fin   (spi_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= T_IDLE;
      mod_q <= '0;
      cfg_q <= '0;
      dev_q <= '0;
      idx_q <= '0;
      go    <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      go <= 1'b0;
      case (st)
        T_IDLE: begin
          if (start) begin
            mod_q <= strap_mod;
            cfg_q <= strap_cfg;
            dev_q <= '0;
            idx_q <= '0;
            busy  <= 1'b1;
            done  <= 1'b0;
            st    <= T_FETCH;
          end
        end
        T_FETCH: st <= T_EVAL;
        T_EVAL: begin
          if (rom_q.addr == END_MARK) begin
            if (dev_q == DEV_W'(NDEV - 1)) begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= T_IDLE;
            end else begin
              dev_q <= dev_q + 1'b1;
              idx_q <= '0;
              st    <= T_FETCH;
            end
          end else begin
            go <= 1'b1;
            st <= T_WAIT;
          end
        end
        T_WAIT: begin
          if (spi_fin) begin
            idx_q <= idx_q + 1'b1;
            st    <= T_FETCH;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cs_n == 3'b111 && !sclk && !busy && !done));
  p_done_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  p_strap_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(mod_q) && $stable(cfg_q)));
  p_dev_order_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (dev_q >= $past(dev_q)));
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (st == T_EVAL) |-> (idx_q < IDX_W'(2**IDX_W - 1)));
endmodule

// File: tb/clk_cfg_seq_tb.sv
module clk_cfg_seq_tb;
  localparam int HALF = 2;
  localparam int MAXW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] strap_mod = '0, strap_cfg = '0;
  logic sclk, mosi, busy, done;
  logic [2:0] cs_n;

  always #5 clk = ~clk;

  clk_cfg_seq #(.SCLK_HALF(HALF)) u_dut (
    .clk(clk), .rst(rst), .start(start), .strap_mod(strap_mod),
    .strap_cfg(strap_cfg), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .done(done)
  );

  int tests = 0, fails = 0;
  int n_exp = 0, n_cap = 0;
  int exp_dev [MAXW];
  logic [23:0] exp_word [MAXW];
  logic [2:0]  cap_cs [MAXW];
  logic [23:0] cap_word [MAXW];
  int          cap_bits [MAXW];
  int gap_bad = 0, cs_bad = 0, gap_cnt = 0, nbits = 0;
  logic [23:0] shreg = '0;
  logic prev_sclk = 1'b0;
  logic [2:0] prev_cs = 3'b111;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic add(input int d, input logic [7:0] a, input logic [7:0] v);
    exp_dev[n_exp] = d;
    exp_word[n_exp] = {8'h00, a, v};
    n_exp++;
  endtask

  // expected write lists derived from R3, R7-R10
  task automatic build_exp(input int m, input int c);
    int mm, cc;
    mm = (m == 3) ? 0 : m;
    cc = (c == 3) ? 0 : c;
    n_exp = 0;
    if (mm == 2 && cc == 0) begin
      add(0, 8'h45, 8'h01); add(0, 8'h4A, 8'h33); add(0, 8'h4B, 8'h00);
      add(0, 8'h3D, 8'h08); add(0, 8'h5A, 8'h01);
    end
    add(1, 8'h45, (mm == 0 || (mm == 1 && cc == 0)) ? 8'h01 : 8'h00);
    add(1, 8'h51, 8'h80); add(1, 8'h5A, 8'h01);
    if (mm == 0) begin
      add(2, 8'h00, 8'h30); add(2, 8'h00, 8'h10); add(2, 8'h0A, 8'h11);
      for (int k = 0; k < 3; k++) add(2, 8'h3D + 8'(k), 8'h03);
      add(2, 8'h40, 8'h01); add(2, 8'h41, 8'h01);
    end else if (mm == 2) begin
      add(2, 8'h00, 8'h30); add(2, 8'h00, 8'h10); add(2, 8'h04, 8'h02);
      add(2, 8'h05, 8'h00); add(2, 8'h06, 8'h03); add(2, 8'h0B, 8'h00);
      add(2, 8'h0C, 8'h01); add(2, 8'h07, 8'h00); add(2, 8'h08, 8'h47);
      add(2, 8'h09, 8'h70); add(2, 8'h0A, (cc == 2) ? 8'h40 : 8'h08);
      for (int k = 0; k < 3; k++) add(2, 8'h3D + 8'(k), 8'h03);
      add(2, 8'h40, (cc == 0) ? 8'h01 : 8'h02); add(2, 8'h41, 8'h02);
      add(2, 8'h51, 8'h80); add(2, 8'h53, 8'h80);
      add(2, 8'h45, 8'h02); add(2, 8'h5A, 8'h01);
    end
  endtask

  // SPI slave model, sampling between edges
  always @(negedge clk) begin
    if (cs_n != 3'b111 && sclk && !prev_sclk) begin
      shreg = {shreg[22:0], mosi};
      nbits++;
    end
    if (cs_n != 3'b111 && prev_cs == 3'b111) begin
      if (n_cap > 0 && gap_cnt + 1 < 2*HALF) gap_bad++;
      if ($countones(~cs_n) != 1) cs_bad++;
      nbits = 0;
    end else if (cs_n != 3'b111 && prev_cs != 3'b111 && cs_n != prev_cs) begin
      cs_bad++;
    end
    if (cs_n == 3'b111 && prev_cs != 3'b111) begin
      if (n_cap < MAXW) begin
        cap_cs[n_cap] = prev_cs;
        cap_word[n_cap] = shreg;
        cap_bits[n_cap] = nbits;
      end
      n_cap++;
      gap_cnt = 0;
    end else if (cs_n == 3'b111) begin
      gap_cnt++;
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic run_case(input int m, input int c, input bit disturb);
    bit finished;
    int bad_i;
    string rq;
    build_exp(m, c);
    n_cap = 0; gap_bad = 0; cs_bad = 0;
    @(posedge clk); #1;
    strap_mod = 2'(m); strap_cfg = 2'(c); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      strap_mod = ~2'(m); strap_cfg = ~2'(c);
      repeat (50) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    finished = 0;
    for (int t = 0; t < 20000 && !finished; t++) begin
      @(negedge clk);
      if (done) finished = 1;
    end
    chk(finished, "R12", "run completes with done", finished, 1);
    chk(n_cap == n_exp, (m == 3 || c == 3) ? "R3" : (disturb ? "R2" : "R6"),
        "frame count", n_cap, n_exp);
    bad_i = -1;
    for (int i = 0; i < n_exp && i < n_cap && i < MAXW; i++) begin
      if (bad_i < 0 && (cap_word[i] != exp_word[i] ||
                        cap_cs[i] != ~(3'(1) << exp_dev[i])))
        bad_i = i;
    end
    if (bad_i < 0) begin
      chk(1, "R4", "contents", 0, 0);
    end else begin
      if (exp_dev[bad_i] == 0) rq = "R7";
      else if (exp_dev[bad_i] == 1) rq = "R8";
      else if (m == 2) rq = "R10";
      else rq = "R9";
      chk(0, rq, "frame contents / chip select",
          {cap_cs[bad_i], cap_word[bad_i]},
          {~(3'(1) << exp_dev[bad_i]), exp_word[bad_i]});
    end
    bad_i = -1;
    for (int i = 0; i < n_cap && i < MAXW; i++)
      if (bad_i < 0 && (cap_bits[i] != 24 || cap_word[i][23:16] != 8'h00)) bad_i = i;
    chk(bad_i < 0, "R5", "24-bit write frame", (bad_i < 0) ? 0 : cap_bits[bad_i], 24);
    chk(gap_bad == 0, "R11", "inter-frame gap violations", gap_bad, 0);
    chk(cs_bad == 0, "R4", "chip select overlap", cs_bad, 0);
    repeat (100) @(negedge clk);
    chk(done && !busy && cs_n == 3'b111, "R12", "done held idle",
        {done, busy, cs_n}, 5'b10111);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 3'b111 && !sclk && !busy && !done, "R1", "reset outputs",
        {cs_n, sclk, busy, done}, 6'b111000);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 3'b111 && !sclk && !busy && !done, "R1", "idle after reset",
        {cs_n, sclk, busy, done}, 6'b111000);
    run_case(0, 0, 0);   // R9 power-down
    run_case(1, 0, 0);   // R8 MMCX-A
    run_case(1, 1, 0);
    run_case(1, 2, 0);
    run_case(2, 0, 0);   // R7 and R10
    run_case(2, 1, 0);
    run_case(2, 2, 0);
    run_case(3, 2, 0);   // R3 reserved module code
    run_case(2, 3, 0);   // R3 reserved letter code
    run_case(2, 1, 1);   // R2 strap change and extra start mid-run
    for (int r = 0; r < 6; r++)
      run_case(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule